// File: doc/BRIEF.md
# I2C Slave Register Access Engine

This block is the serial front end of a small register-mapped device. A fast system clock samples the two bus lines. Each line passes through a two-flop synchronizer and a glitch-rejecting hold counter. The block then detects START, repeated START and STOP, and it checks the identification byte against a 7-bit pattern built from a fixed prefix and two strap inputs.

A write is one identification byte, one address byte and exactly one data byte. The data byte becomes a single-cycle write strobe on a simple back-end port. A read first sets the pointer with an address byte. A repeated START and a read-type identification byte follow. The block then streams register bytes, supplied combinationally by the back end at the pointer address, for as long as the master acknowledges. The pointer steps after each byte and wraps at a parameterised top address.

The block only drives an open-drain pull-down enable for SDA. Pad behaviour and register storage are outside it.

Top module: `i2c_regport`

## Requirements
- R1: After reset `sda_pull` and `wr_en` are low.
- R2: Bus traffic is ignored until a START. After any STOP the block is idle, and clocked bytes without a new START receive no acknowledge.
- R3: The identification byte is sent MSB first. Its seven upper bits must equal binary 10100 followed by `strap[1]` and then `strap[0]`, and bit 0 is the direction (1 = read, 0 = write). On a match the block pulls SDA low during the ninth clock.
- R4: After a write-type identification byte, the address byte is acknowledged and loaded into `reg_addr`. The next data byte is acknowledged and produces exactly one `wr_en` cycle, with `wr_data` equal to the byte and `reg_addr` equal to the address.
- R5: Only one data byte is accepted per write. Further bytes before the next START get no acknowledge and no strobe.
- R6: A non-matching identification byte gets no acknowledge, and SDA stays released until the next START.
- R7: After a repeated START and a read-type identification byte, the block sends `rd_data` for the current `reg_addr` MSB first. It changes SDA only after SCL falling edges, and it keeps sending further bytes while the master acknowledges.
- R8: The read pointer advances by one after each byte sent. At `WRAP_ADDR` (default 0x0F) it returns to 0x00, and other values simply increment.
- R9: If `busy` is high when the last bit of a write data byte ends, that byte gets no acknowledge and no strobe.
- R10: Pulses on SCL or SDA shorter than `FILT_CYC` clock cycles have no effect on the transfer.
- R11: A master NACK after a read byte ends the transmission: SDA stays released until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull | output | 1 | High pulls SDA low (open-drain enable) |
| strap | input | 2 | Address straps, bits 2..1 of the identification byte |
| reg_addr | output | 8 | Register pointer / address to the back end |
| wr_data | output | 8 | Write data to the back end |
| wr_en | output | 1 | One-cycle write strobe |
| rd_data | input | 8 | Read data for `reg_addr`, combinational from the back end |
| busy | input | 1 | Back end cannot accept a write |

## Verification
The bench builds the block with `FILT_CYC` = 4 and the default wrap address of 0x0F. With a 25-cycle quarter bit period, two-cycle spikes on SCL and SDA can be placed inside single bit cells, so both rejection paths are reached without long runs. The default wrap address lets a short read started at 0x0D cross the rollover, and a read started at 0x20 shows plain incrementing.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] ID_PREFIX = 5'b10100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID,
    ST_ADDR,
    ST_WDAT,
    ST_RDAT,
    ST_HOLD
  } st_e;
endpackage

// File: rtl/i2cr_glitch.sv
// Two-flop synchronizer followed by a hold counter: the clean output
// follows the input only after FILT_CYC consecutive cycles of difference.
module i2cr_glitch #(
  parameter int FILT_CYC = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          clean_nx;

  always_comb begin
    cnt_nx   = cnt_q;
    clean_nx = clean;
    if (sync_q[1] == clean) begin
      cnt_nx = '0;
    end else if (cnt_q == CW'(FILT_CYC - 1)) begin
      cnt_nx   = '0;
      clean_nx = sync_q[1];
    end else begin
      cnt_nx = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      clean  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw};
      cnt_q  <= cnt_nx;
      clean  <= clean_nx;
    end
  end
endmodule

// File: rtl/i2cr_cond.sv
// Bus condition detector on the filtered lines.
module i2cr_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start,
  output logic stop,
  output logic rise,
  output logic fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign start = scl & scl_q & sda_q & ~sda;
  assign stop  = scl & scl_q & ~sda_q & sda;
  assign rise  = scl & ~scl_q;
  assign fall  = ~scl & scl_q;
endmodule

// File: rtl/i2cr_engine.sv
// Byte/bit sequencer: identification, address, write data, read stream.
module i2cr_engine
  import i2cr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] WRAP_ADDR = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              rise,
  input  logic              fall,
  input  logic              sda,
  input  logic [1:0]        strap,
  input  logic              busy,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] ptr,
  output logic [BYTE_W-1:0] wdat,
  output logic              wen,
  output logic              rd_act
);
  st_e               st_q, st_nx, go_q, go_nx;
  logic [3:0]        bitc_q, bitc_nx;
  logic              ackph_q, ackph_nx;
  logic              mack_q, mack_nx;
  logic [BYTE_W-1:0] shr_q, shr_nx, txs_q, txs_nx;
  logic [BYTE_W-1:0] ptr_nx, wdat_nx, ptr_step;
  logic              pull_nx, wen_nx, id_ok;

  assign id_ok    = (shr_q[7:1] == {ID_PREFIX, strap});
  assign ptr_step = (ptr == WRAP_ADDR) ? '0 : ptr + 1'b1;
  assign rd_act   = (st_q == ST_RDAT);

  always_comb begin
    st_nx    = st_q;
    go_nx    = go_q;
    bitc_nx  = bitc_q;
    ackph_nx = ackph_q;
    mack_nx  = mack_q;
    shr_nx   = shr_q;
    txs_nx   = txs_q;
    ptr_nx   = ptr;
    wdat_nx  = wdat;
    pull_nx  = sda_pull;
    wen_nx   = 1'b0;
    if (stop || start) begin
      st_nx    = stop ? ST_IDLE : ST_ID;
      bitc_nx  = '0;
      ackph_nx = 1'b0;
      pull_nx  = 1'b0;
    end else begin
      case (st_q)
        ST_ID, ST_ADDR, ST_WDAT: begin
          if (rise && !ackph_q && bitc_q != 4'd8) begin
            shr_nx  = {shr_q[6:0], sda};
            bitc_nx = bitc_q + 1'b1;
          end
          if (fall && ackph_q) begin
            ackph_nx = 1'b0;
            bitc_nx  = '0;
            pull_nx  = 1'b0;
            st_nx    = go_q;
            if (go_q == ST_RDAT) begin
              txs_nx  = rd_data;
              pull_nx = ~rd_data[7];
            end
          end else if (fall && bitc_q == 4'd8) begin
            if (st_q == ST_ID) begin
              if (id_ok) begin
                ackph_nx = 1'b1;
                pull_nx  = 1'b1;
                go_nx    = shr_q[0] ? ST_RDAT : ST_ADDR;
              end else begin
                st_nx = ST_HOLD;
              end
            end else if (st_q == ST_ADDR) begin
              ackph_nx = 1'b1;
              pull_nx  = 1'b1;
              ptr_nx   = shr_q;
              go_nx    = ST_WDAT;
            end else if (!busy) begin
              ackph_nx = 1'b1;
              pull_nx  = 1'b1;
              wen_nx   = 1'b1;
              wdat_nx  = shr_q;
              go_nx    = ST_HOLD;
            end else begin
              st_nx = ST_HOLD;
            end
          end
        end
        ST_RDAT: begin
          if (rise) begin
            if (ackph_q) mack_nx = sda;
            else         bitc_nx = bitc_q + 1'b1;
          end
          if (fall) begin
            if (ackph_q) begin
              ackph_nx = 1'b0;
              if (!mack_q) begin
                txs_nx  = rd_data;
                pull_nx = ~rd_data[7];
                bitc_nx = '0;
              end else begin
                st_nx   = ST_HOLD;
                pull_nx = 1'b0;
              end
            end else if (bitc_q == 4'd8) begin
              pull_nx  = 1'b0;
              ackph_nx = 1'b1;
              ptr_nx   = ptr_step;
            end else begin
              txs_nx  = {txs_q[6:0], 1'b0};
              pull_nx = ~txs_q[6];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      go_q     <= ST_IDLE;
      bitc_q   <= '0;
      ackph_q  <= 1'b0;
      mack_q   <= 1'b1;
      shr_q    <= '0;
      txs_q    <= '0;
      ptr      <= '0;
      wdat     <= '0;
      sda_pull <= 1'b0;
      wen      <= 1'b0;
    end else begin
      st_q     <= st_nx;
      go_q     <= go_nx;
      bitc_q   <= bitc_nx;
      ackph_q  <= ackph_nx;
      mack_q   <= mack_nx;
      shr_q    <= shr_nx;
      txs_q    <= txs_nx;
      ptr      <= ptr_nx;
      wdat     <= wdat_nx;
      sda_pull <= pull_nx;
      wen      <= wen_nx;
    end
  end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2cr_pkg::*;
#(
  parameter int                FILT_CYC  = 13,
  parameter logic [BYTE_W-1:0] WRAP_ADDR = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  input  logic [1:0]        strap,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_en,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              busy
);
  localparam int NLINE = 2;

  logic [1:0]       rst_sync;
  logic             rst_s;
  logic [NLINE-1:0] raw_line, clean_line;
  logic             cond_start, cond_stop, scl_rise, scl_fall, rd_act;

  // Reset asserts asynchronously and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  assign raw_line = {sda_in, scl_in};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    i2cr_glitch #(.FILT_CYC(FILT_CYC)) u_flt (
      .clk  (clk),
      .rst_n(rst_s),
      .raw  (raw_line[g]),
      .clean(clean_line[g])
    );
  end

  i2cr_cond u_cond (
    .clk  (clk),
    .rst_n(rst_s),
    .scl  (clean_line[0]),
    .sda  (clean_line[1]),
    .start(cond_start),
    .stop (cond_stop),
    .rise (scl_rise),
    .fall (scl_fall)
  );

  i2cr_engine #(.WRAP_ADDR(WRAP_ADDR)) u_eng (
    .clk     (clk),
    .rst_n   (rst_s),
    .start   (cond_start),
    .stop    (cond_stop),
    .rise    (scl_rise),
    .fall    (scl_fall),
    .sda     (clean_line[1]),
    .strap   (strap),
    .busy    (busy),
    .rd_data (rd_data),
    .sda_pull(sda_pull),
    .ptr     (reg_addr),
    .wdat    (wr_data),
    .wen     (wr_en),
    .rd_act  (rd_act)
  );
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk #(
  parameter logic [7:0] WRAP_ADDR = 8'h0F
) (
  input logic       clk,
  input logic       rst_s,
  input logic       sda_pull,
  input logic       wr_en,
  input logic       busy,
  input logic [7:0] reg_addr,
  input logic       rd_act,
  input logic       scl_fall,
  input logic       cond_start,
  input logic       cond_stop
);
  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_s)
    wr_en |=> !wr_en);

  // R9
  strobe_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_s)
    wr_en |-> !$past(busy));

  // R7
  pull_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !$stable(sda_pull) |-> $past(scl_fall || cond_start || cond_stop));

  // R8
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!$stable(reg_addr) && $past(rd_act)) |->
      reg_addr == (($past(reg_addr) == WRAP_ADDR) ? 8'h00 : 8'($past(reg_addr) + 8'd1)));
endmodule

bind i2c_regport i2c_regport_chk #(.WRAP_ADDR(WRAP_ADDR)) u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .sda_pull  (sda_pull),
  .wr_en     (wr_en),
  .busy      (busy),
  .reg_addr  (reg_addr),
  .rd_act    (rd_act),
  .scl_fall  (scl_fall),
  .cond_start(cond_start),
  .cond_stop (cond_stop)
);

// File: tb/sim_i2c_regport.sv
`timescale 1ns/1ps
module sim_i2c_regport;
  localparam int Q = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic       busy = 1'b0;
  logic       sda_pull, wr_en;
  logic [7:0] reg_addr, wr_data, rd_data;
  wire        sda_line = sda_m & ~sda_pull;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;

  function automatic logic [7:0] mdl(input logic [7:0] a);
    return 8'(a * 8'd29) ^ 8'h5A;
  endfunction
  assign rd_data = mdl(reg_addr);

  i2c_regport #(.FILT_CYC(4)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_m),
    .sda_pull(sda_pull), .strap(strap), .reg_addr(reg_addr),
    .wr_data(wr_data), .wr_en(wr_en), .rd_data(rd_data), .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each write strobe with the queue head.
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_q.size() == 0) begin
        chk(0, "R5 unexpected strobe", {reg_addr, wr_data}, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk({reg_addr, wr_data} == e, "R4 write addr/data", {reg_addr, wr_data}, e);
      end
    end
  end

  task automatic cyc(input int n); repeat (n) @(posedge clk); endtask

  task automatic bstart();
    sda_m = 1; cyc(Q); scl_m = 1; cyc(Q); sda_m = 0; cyc(Q); scl_m = 0; cyc(Q);
  endtask
  task automatic bstop();
    sda_m = 0; cyc(Q); scl_m = 1; cyc(Q); sda_m = 1; cyc(2 * Q);
  endtask

  // One bit cell; glitchy adds short spikes on SCL (low phase) and SDA (high phase).
  task automatic bbit(input logic b, input bit glitchy, output logic smp);
    sda_m = b;
    if (glitchy) begin cyc(8); scl_m = 1; cyc(2); scl_m = 0; cyc(Q - 10); end
    else cyc(Q);
    scl_m = 1; cyc(Q);
    @(negedge clk); smp = sda_line;
    if (glitchy && b) begin sda_m = 0; cyc(2); sda_m = 1; cyc(Q - 2); end
    else cyc(Q);
    scl_m = 0; cyc(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, input bit glitchy, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bbit(d[i], glitchy, s);
    bbit(1'b1, glitchy, ack);
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin bbit(1'b1, 0, s); d[i] = s; end
    bbit(mack, 0, s);
  endtask

  task automatic do_write(input logic [1:0] idstrap, input logic [7:0] a,
                          input logic [7:0] d, input bit glitchy, output logic [2:0] acks);
    logic k;
    bstart();
    wbyte({5'b10100, idstrap, 1'b0}, glitchy, k); acks[2] = k;
    wbyte(a, glitchy, k); acks[1] = k;
    wbyte(d, glitchy, k); acks[0] = k;
  endtask

  task automatic do_read(input logic [7:0] a, input int n);
    logic k;
    logic [7:0] d;
    logic [7:0] p;
    bstart();
    wbyte({5'b10100, strap, 1'b0}, 0, k);
    chk(k == 0, "R3 id ack (read setup)", k, 0);
    wbyte(a, 0, k);
    chk(k == 0, "R4 address ack", k, 0);
    bstart();
    wbyte({5'b10100, strap, 1'b1}, 0, k);
    chk(k == 0, "R3 read id ack", k, 0);
    p = a;
    for (int i = 0; i < n; i++) begin
      rbyte((i == n - 1), d);
      chk(d == mdl(p), "R7 R8 read byte", d, mdl(p));
      p = (p == 8'h0F) ? 8'h00 : 8'(p + 1);
    end
    // R11: after the NACK the slave stays off the line.
    rbyte(1'b1, d);
    chk(d == 8'hFF, "R11 released after NACK", d, 8'hFF);
    bstop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] acks;
    logic k;
    cyc(5); rst_n = 1; cyc(10);
    // R1
    chk(sda_pull == 0, "R1 reset pull", sda_pull, 0);
    chk(wr_en == 0, "R1 reset strobe", wr_en, 0);

    // R3 R4: plain write
    exp_q.push_back({8'h03, 8'h5C});
    do_write(strap, 8'h03, 8'h5C, 0, acks);
    chk(acks == 3'b000, "R3 R4 write acks", acks, 0);
    bstop(); cyc(20);
    chk(exp_q.size() == 0, "R4 strobe seen", exp_q.size(), 0);

    // R5: extra data byte ignored
    exp_q.push_back({8'h07, 8'h11});
    do_write(strap, 8'h07, 8'h11, 0, acks);
    wbyte(8'h22, 0, k);
    chk(k == 1, "R5 extra byte no ack", k, 1);
    bstop(); cyc(20);
    chk(exp_q.size() == 0, "R5 one strobe", exp_q.size(), 0);

    // R6: wrong straps
    do_write(~strap, 8'h04, 8'h33, 0, acks);
    chk(acks == 3'b111, "R6 mismatch no ack", acks, 3'b111);
    bstop(); cyc(20);

    // R9: busy back end
    busy = 1;
    exp_q.delete();
    do_write(strap, 8'h02, 8'h99, 0, acks);
    chk(acks == 3'b001, "R9 busy data nack", acks, 3'b001);
    bstop(); cyc(20); busy = 0;

    // R7 R8 R11: sequential read across the wrap, and a plain increment
    do_read(8'h0D, 5);
    do_read(8'h20, 2);

    // R2: bytes after STOP without START
    wbyte({5'b10100, strap, 1'b0}, 0, k);
    chk(k == 1, "R2 no start no ack", k, 1);
    cyc(20);

    // R10: spikes on both lines during a write with other straps
    strap = 2'b01;
    exp_q.push_back({8'h0A, 8'h6B});
    do_write(strap, 8'h0A, 8'h6B, 1, acks);
    chk(acks == 3'b000, "R10 acks under spikes", acks, 0);
    bstop(); cyc(20);
    chk(exp_q.size() == 0, "R10 strobe under spikes", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule